// File: doc/BRIEF.md
# Instruction Queue with Prefetch Bypass

This block sits between an instruction line buffer and the decode stage. Each clock the line buffer can offer up to two instruction words on two lanes. Lane 0 always holds the older word. The queue passes one word per cycle to decode. When decode is free and nothing is waiting, an incoming word reaches decode in the same cycle through a combinational bypass, with no register in the path. When decode stalls, incoming words are parked in two holding slots, slot 0 and slot 1. Decode then empties these slots, oldest first, before it takes any new word.

Acceptance is all or nothing. The queue raises its ready output only when every word offered in that cycle fits. The space it counts is the free holding slots plus the one word decode takes in that cycle, if decode is ready. A flush drops every held word, blocks the bypass and discards whatever is offered in that cycle.

Top module: `iq_bypass`

## Requirements
- R1: While and directly after reset, with nothing offered, `dec_valid` is 0 and `in_ready` is 1.
- R2: With both holding slots empty and no flush, a valid lane 0 word appears on `dec_instr` with `dec_valid` high in the same cycle it is offered.
- R3: Decode receives words in offer order: slot 0 first, then slot 1, then lane 0, then lane 1 of the current cycle. Words from an earlier cycle always come before words from a later one.
- R4: No accepted word is lost or duplicated, and the queue never holds more than two words.
- R5: The number of words offered is 0 when `in_valid[0]`=0, 1 when `in_valid`=2'b01, and 2 when `in_valid`=2'b11. `in_ready` is 1 exactly when this number is no greater than the free slots plus 1 when `dec_ready` is high.
- R6: `in_valid`=2'b10 counts as nothing offered. Lane 1 is ignored and nothing is stored or passed to decode.
- R7: In a flush cycle `dec_valid` is 0, both holding slots are emptied, and the offered words are discarded.
- R8: At most one word leaves per cycle. While `dec_valid` is high and `dec_ready` is low, with no flush, the next cycle shows the same word with `dec_valid` still high.
- R9: When `in_ready` is 0, none of the offered words is taken. Later output contains only the words that were taken before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard held and offered words this cycle |
| in_valid | input | 2 | Lane valid bits; bit 0 is the older lane |
| in_instr0 | input | W | Lane 0 instruction word |
| in_instr1 | input | W | Lane 1 instruction word |
| in_ready | output | 1 | All offered words are taken this cycle |
| dec_ready | input | 1 | Decode takes the presented word this cycle |
| dec_valid | output | 1 | A word is presented to decode |
| dec_instr | output | W | Word presented to decode |

## Verification
The bench offers pairs while decode is stalled. A queue that counts its space wrongly would then keep `in_ready` high while full and overwrite slot 1, or drop ready while it still has room. It drains mixed held and fresh words and checks the order. A swapped mux shows up as slot 1 or lane 0 reaching decode ahead of slot 0. It flushes with both slots full and while a word is being bypassed. A design that left the count standing would present stale words afterwards, and one that kept the bypass open would show a valid word in the flush cycle. A lone lane 1 valid must leave no trace, or a phantom word comes out next.

// File: rtl/iq_bypass.sv
module iq_bypass #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [1:0]   in_valid,
  input  logic [W-1:0] in_instr0,
  input  logic [W-1:0] in_instr1,
  output logic         in_ready,
  input  logic         dec_ready,
  output logic         dec_valid,
  output logic [W-1:0] dec_instr
);

  logic [W-1:0] slot0, slot1;
  logic [1:0]   cnt;

  logic       lane0, lane1;
  logic [1:0] offered;
  logic [2:0] room;
  logic [1:0] taken;
  logic       pop;
  logic [2:0] next_cnt;
  logic [W-1:0] seq0, seq1, seq2;

  assign lane0   = in_valid[0];
  assign lane1   = in_valid[0] & in_valid[1];
  assign offered = lane1 ? 2'd2 : (lane0 ? 2'd1 : 2'd0);
  assign room    = 3'd2 - {1'b0, cnt} + {2'b00, dec_ready};
  assign in_ready = room >= {1'b0, offered};
  assign taken   = (in_ready && !flush) ? offered : 2'd0;

  assign dec_valid = !flush && (cnt != 2'd0 || lane0);
  assign dec_instr = (cnt != 2'd0) ? slot0 : in_instr0;
  assign pop       = dec_valid && dec_ready;

  always_comb begin
    seq0 = (cnt != 2'd0) ? slot0 : in_instr0;
    case (cnt)
      2'd0:    seq1 = in_instr1;
      2'd1:    seq1 = in_instr0;
      default: seq1 = slot1;
    endcase
    seq2 = (cnt == 2'd2) ? in_instr0 : in_instr1;
  end

  assign next_cnt = {1'b0, cnt} + {1'b0, taken} - {2'b00, pop};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= 2'd0;
      slot0 <= '0;
      slot1 <= '0;
    end else if (flush) begin
      cnt <= 2'd0;
    end else begin
      cnt   <= next_cnt[1:0];
      slot0 <= pop ? seq1 : seq0;
      slot1 <= pop ? seq2 : seq1;
    end
  end

endmodule

// File: rtl/iq_bypass_chk.sv
module iq_bypass_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic [1:0]   in_valid,
  input logic [W-1:0] in_instr0,
  input logic         in_ready,
  input logic         dec_ready,
  input logic         dec_valid,
  input logic [W-1:0] dec_instr
);

  logic [2:0] occ;
  logic [2:0] n_off;

  assign n_off = in_valid[0] ? (in_valid[1] ? 3'd2 : 3'd1) : 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      occ <= 3'd0;
    else if (flush)
      occ <= 3'd0;
    else
      occ <= occ + (in_ready ? n_off : 3'd0) - {2'b00, dec_valid && dec_ready};
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 3'd2);

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 3'd0 && in_valid[0] && !flush) |-> (dec_valid && dec_instr == in_instr0));

  assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 3'd2 && !dec_ready && in_valid[0]) |-> !in_ready);

  assert_flush_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !dec_valid);

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (in_valid[0] || !dec_valid));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready && !flush) |=> (flush || (dec_valid && $stable(dec_instr))));

  assert_lane1_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 3'd0 && in_valid == 2'b10) |-> !dec_valid);

endmodule

bind iq_bypass iq_bypass_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
  .in_instr0(in_instr0), .in_ready(in_ready), .dec_ready(dec_ready),
  .dec_valid(dec_valid), .dec_instr(dec_instr)
);

// File: tb/iq_bypass_test.sv
`timescale 1ns/1ps
module iq_bypass_test;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [1:0] in_valid = 2'b00;
  logic [W-1:0] in_instr0 = '0, in_instr1 = '0;
  logic dec_ready = 1'b0;
  logic in_ready, dec_valid;
  logic [W-1:0] dec_instr;

  always #2.5 clk = ~clk;

  iq_bypass #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_instr0(in_instr0), .in_instr1(in_instr1), .in_ready(in_ready),
    .dec_ready(dec_ready), .dec_valid(dec_valid), .dec_instr(dec_instr)
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] mq [3];
  int mcnt = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic r, input logic f, input string tag);
    int n;
    logic er, ev;
    @(negedge clk);
    in_valid = v; in_instr0 = a; in_instr1 = b; dec_ready = r; flush = f;
    #1;
    n  = v[0] ? (v[1] ? 2 : 1) : 0;
    er = ((2 - mcnt + (r ? 1 : 0)) >= n);
    ev = !f && (mcnt > 0 || v[0]);
    check({tag, " in_ready"}, {31'b0, in_ready}, {31'b0, er});
    check({tag, " dec_valid"}, {31'b0, dec_valid}, {31'b0, ev});
    if (ev) check({tag, " dec_instr"}, dec_instr, (mcnt > 0) ? mq[0] : a);
    if (f) mcnt = 0;
    else begin
      if (er && n >= 1) begin mq[mcnt] = a; mcnt++; end
      if (er && n == 2) begin mq[mcnt] = b; mcnt++; end
      if (ev && r) begin mq[0] = mq[1]; mq[1] = mq[2]; mcnt--; end
    end
  endtask

  task automatic idle(input logic r, input string tag);
    step(2'b00, '0, '0, r, 1'b0, tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset in_ready", {31'b0, in_ready}, 32'd1);
    check("R1 in reset dec_valid", {31'b0, dec_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mcnt = 0;
    idle(1'b1, "R1 after reset");
  endtask

  task automatic t_bypass;
    for (int i = 0; i < 5; i++)
      step(2'b01, 32'hA000_0000 + i, 32'hDEAD_0000 + i, 1'b1, 1'b0, "R2 bypass");
    idle(1'b1, "R2 empty after bypass");
  endtask

  task automatic t_pairs;
    for (int i = 0; i < 6; i++)
      step(2'b11, 32'hB000_0000 + 2*i, 32'hB000_0001 + 2*i, 1'b1, 1'b0, "R3 R5 pairs");
    for (int i = 0; i < 3; i++) idle(1'b1, "R3 drain pairs");
  endtask

  task automatic t_stall;
    step(2'b11, 32'hC000_0000, 32'hC000_0001, 1'b0, 1'b0, "R4 fill");
    step(2'b01, 32'hC000_0002, '0, 1'b0, 1'b0, "R9 full refuse");
    step(2'b11, 32'hC000_0003, 32'hC000_0004, 1'b0, 1'b0, "R9 full refuse pair");
    idle(1'b0, "R8 hold");
    step(2'b11, 32'hC000_0005, 32'hC000_0006, 1'b1, 1'b0, "R5 pair needs two slots");
    step(2'b01, 32'hC000_0007, '0, 1'b1, 1'b0, "R3 slot before lane");
    step(2'b11, 32'hC000_0008, 32'hC000_0009, 1'b0, 1'b0, "R5 one slot free");
    for (int i = 0; i < 3; i++) idle(1'b1, "R3 R4 drain");
  endtask

  task automatic t_lane1;
    step(2'b10, 32'hE000_0000, 32'hE000_0001, 1'b0, 1'b0, "R6 lone lane1");
    idle(1'b1, "R6 nothing stored");
    step(2'b10, 32'hE000_0002, 32'hE000_0003, 1'b1, 1'b0, "R6 lone lane1 ready");
    idle(1'b1, "R6 nothing stored again");
  endtask

  task automatic t_flush;
    step(2'b11, 32'hF000_0000, 32'hF000_0001, 1'b0, 1'b0, "R7 fill");
    step(2'b11, 32'hF000_0002, 32'hF000_0003, 1'b1, 1'b1, "R7 flush full");
    idle(1'b1, "R7 empty after flush");
    step(2'b01, 32'hF000_0004, '0, 1'b1, 1'b1, "R7 flush kills bypass");
    idle(1'b1, "R7 no stale after bypass kill");
    step(2'b01, 32'hF000_0005, '0, 1'b1, 1'b0, "R7 R2 resume");
    idle(1'b1, "R7 end");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bypass();
    t_pairs();
    t_stall();
    t_lane1();
    t_flush();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule